// File: doc/BRIEF.md
# CAN Node Bit-Rate Service Handler

This block is the node-side responder for the two bit-timing services of the layer-setting protocol on a CAN node. It watches decoded receive frames (identifier, length code, eight data bytes, valid strobe). It answers "configure" requests with a status frame on a valid/ready transmit port. It performs "activate" requests after a switch delay counted in milliseconds.

Three bit-rate index registers are kept. The pending index is written by configure requests. The active index is the one the node's bit timing uses. The persistent index stands in for non-volatile storage. A store strobe copies pending into persistent. On power-on the persistent register takes a parameter value. On any reset the active and pending indices are loaded from the persistent one.

An activate request starts a switch delay of D milliseconds, counted on a one-cycle tick input. When the first D ticks have passed, pending is copied to active. The node then stays busy for D more ticks, so it keeps off the bus for twice the delay. The active index is also shown as a rate in kbit/s.

Top module: `bitrate_svc_handler`

## Requirements
- R1: A frame is taken only if its identifier is 7E5h, its length code is 8 and byte 0 is 13h (configure) or 15h (activate). Any other frame sends no response and leaves every index unchanged. Byte n of a frame sits at data bits [8n+7:8n].
- R2: A configure request whose byte 2 holds a supported index (0 to 4 or 6 to 8) writes that index to pending. One cycle later tx_valid rises with identifier 7E4h, length 8, byte 0 = 13h, byte 1 = 00h and bytes 2 to 7 zero.
- R3: Index 5 is reserved. A configure request with byte 2 equal to 5 is answered with byte 1 = 01h and leaves pending unchanged.
- R4: A configure request with byte 2 above 8 is answered with byte 1 = 01h and leaves pending unchanged.
- R5: A configure request never changes the active or the persistent index.
- R6: tx_valid and tx_data hold until a cycle with tx_ready high. While a response is outstanding, every request is ignored.
- R7: An activate request takes its delay D from byte 1 (low) and byte 2 (high). It sends no response. Pending is copied to active once D ticks have been counted after the request, and not before.
- R8: busy is high from the cycle after an activate request until 2·D ticks have been counted. While busy is high, every request is ignored.
- R9: A cycle with store_cfg high copies the pending index into the persistent index. No other event changes persistent outside power-on.
- R10: While por_n is low, persistent takes PERSIST_INIT. While rst_n or por_n is low, active and pending take the persistent value, and tx_valid and busy are low.
- R11: active_kbps gives the active index as a rate: 0→1000, 1→800, 2→500, 3→250, 4→125, 6→50, 7→20, 8→10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Node reset, active low |
| por_n | input | 1 | Power-on reset, active low; also loads persistent |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| rx_valid | input | 1 | Received frame strobe |
| rx_id | input | 11 | Received identifier |
| rx_len | input | 4 | Received length code |
| rx_data | input | 64 | Received bytes, byte n at [8n+7:8n] |
| store_cfg | input | 1 | Copy pending into persistent |
| tx_ready | input | 1 | Transmit side accepts the response |
| tx_valid | output | 1 | Response frame available |
| tx_id | output | 11 | Response identifier |
| tx_len | output | 4 | Response length code |
| tx_data | output | 64 | Response bytes |
| busy | output | 1 | Switch delay running |
| pending_idx | output | IDX_W | Pending bit-rate index |
| active_idx | output | IDX_W | Active bit-rate index |
| persist_idx | output | IDX_W | Persistent bit-rate index |
| active_kbps | output | 10 | Rate of the active index in kbit/s |

## Verification
Configure requests are sent with supported, reserved and out-of-range indices. This separates the accept path from both reject paths, and a check that pending survives each reject confirms it is not written. Frames that are nearly right, with a wrong identifier, a wrong length or an unknown command, show that every decode term matters. A second request sent while the first response is stalled shows that the handshake holds. Activations run with delays of zero, a small value on a slow tick, and a 16-bit value whose two bytes differ. These tell a correct low-byte-first delay from a swapped one and show that the busy window lasts twice the delay. Store and reset pulses then show which register survives which reset.

// File: rtl/bitrate_pkg.sv
package bitrate_pkg;
  localparam logic [10:0] REQ_ID  = 11'h7E5;
  localparam logic [10:0] RSP_ID  = 11'h7E4;
  localparam logic [3:0]  FRM_LEN = 4'd8;
  localparam logic [7:0]  CMD_CFG = 8'h13;
  localparam logic [7:0]  CMD_ACT = 8'h15;
  localparam logic [7:0]  IDX_TOP = 8'd8;
  localparam logic [7:0]  IDX_RSV = 8'd5;
  localparam logic [7:0]  ST_OK   = 8'h00;
  localparam logic [7:0]  ST_BAD  = 8'h01;
  localparam int          RATE_W  = 10;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_FIRST, SEQ_SECOND} seq_state_t;

  function automatic logic [7:0] frame_byte(input logic [63:0] d, input int n);
    return d[8*n +: 8];
  endfunction

  function automatic logic idx_supported(input logic [7:0] idx);
    return (idx <= IDX_TOP) && (idx != IDX_RSV);
  endfunction

  function automatic logic [15:0] le16(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic [RATE_W-1:0] idx_kbps(input logic [7:0] idx);
    case (idx)
      8'd0:    return RATE_W'(1000);
      8'd1:    return RATE_W'(800);
      8'd2:    return RATE_W'(500);
      8'd3:    return RATE_W'(250);
      8'd4:    return RATE_W'(125);
      8'd6:    return RATE_W'(50);
      8'd7:    return RATE_W'(20);
      8'd8:    return RATE_W'(10);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/frame_decoder.sv
module frame_decoder
  import bitrate_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             enable,
  input  logic             rx_valid,
  input  logic [10:0]      rx_id,
  input  logic [3:0]       rx_len,
  input  logic [63:0]      rx_data,
  output logic             cfg_fire,
  output logic             act_fire,
  output logic [7:0]       cfg_idx,
  output logic             cfg_ok,
  output logic [DLY_W-1:0] act_delay
);
  logic frame_hit;
  logic [7:0] cmd;

  always_comb begin
    frame_hit = enable && rx_valid && (rx_id == REQ_ID) && (rx_len == FRM_LEN);
    cmd       = frame_byte(rx_data, 0);
    cfg_fire  = frame_hit && (cmd == CMD_CFG);
    act_fire  = frame_hit && (cmd == CMD_ACT);
    cfg_idx   = frame_byte(rx_data, 2);
    cfg_ok    = idx_supported(cfg_idx);
    act_delay = DLY_W'(le16(frame_byte(rx_data, 1), frame_byte(rx_data, 2)));
  end
endmodule

// File: rtl/delay_sequencer.sv
module delay_sequencer
  import bitrate_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DLY_W-1:0] delay,
  input  logic             tick,
  output logic             switch_now,
  output logic             busy
);
  seq_state_t       state_q;
  logic [DLY_W-1:0] rem_q;
  logic [DLY_W-1:0] dly_q;
  logic             rem_zero;

  assign rem_zero   = (rem_q == '0);
  assign switch_now = (state_q == SEQ_FIRST) && rem_zero;
  assign busy       = (state_q != SEQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      rem_q   <= '0;
      dly_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start) begin
          dly_q   <= delay;
          rem_q   <= delay;
          state_q <= SEQ_FIRST;
        end
        SEQ_FIRST: if (rem_zero) begin
          rem_q   <= dly_q;
          state_q <= SEQ_SECOND;
        end else if (tick) begin
          rem_q <= rem_q - 1'b1;
        end
        SEQ_SECOND: if (rem_zero) begin
          state_q <= SEQ_IDLE;
        end else if (tick) begin
          rem_q <= rem_q - 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/resp_builder.sv
module resp_builder
  import bitrate_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        ok,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [63:0] tx_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= {48'h0, (ok ? ST_OK : ST_BAD), CMD_CFG};
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bitrate_svc_handler.sv
module bitrate_svc_handler
  import bitrate_pkg::*;
#(
  parameter int               IDX_W        = 4,
  parameter int               DLY_W        = 16,
  parameter logic [IDX_W-1:0] PERSIST_INIT = IDX_W'(4)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 por_n,
  input  logic                 ms_tick,
  input  logic                 rx_valid,
  input  logic [10:0]          rx_id,
  input  logic [3:0]           rx_len,
  input  logic [63:0]          rx_data,
  input  logic                 store_cfg,
  input  logic                 tx_ready,
  output logic                 tx_valid,
  output logic [10:0]          tx_id,
  output logic [3:0]           tx_len,
  output logic [63:0]          tx_data,
  output logic                 busy,
  output logic [IDX_W-1:0]     pending_idx,
  output logic [IDX_W-1:0]     active_idx,
  output logic [IDX_W-1:0]     persist_idx,
  output logic [RATE_W-1:0]    active_kbps
);
  logic             rst;
  logic             idle;
  logic             cfg_fire;
  logic             act_fire;
  logic [7:0]       cfg_idx;
  logic             cfg_ok;
  logic [DLY_W-1:0] act_delay;
  logic             switch_now;
  logic             cfg_take;

  assign rst      = !rst_n || !por_n;
  assign idle     = !busy && !tx_valid;
  assign cfg_take = cfg_fire && cfg_ok;
  assign tx_id    = RSP_ID;
  assign tx_len   = FRM_LEN;

  frame_decoder #(.DLY_W(DLY_W)) u_dec (
    .enable(idle), .rx_valid(rx_valid), .rx_id(rx_id), .rx_len(rx_len),
    .rx_data(rx_data), .cfg_fire(cfg_fire), .act_fire(act_fire),
    .cfg_idx(cfg_idx), .cfg_ok(cfg_ok), .act_delay(act_delay)
  );

  delay_sequencer #(.DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst(rst), .start(act_fire), .delay(act_delay),
    .tick(ms_tick), .switch_now(switch_now), .busy(busy)
  );

  resp_builder u_rsp (
    .clk(clk), .rst(rst), .load(cfg_fire), .ok(cfg_ok),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
  );

  always_ff @(posedge clk) begin
    if (!por_n)         persist_idx <= PERSIST_INIT;
    else if (store_cfg) persist_idx <= pending_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_idx <= persist_idx;
      active_idx  <= persist_idx;
    end else begin
      if (cfg_take)   pending_idx <= cfg_idx[IDX_W-1:0];
      if (switch_now) active_idx  <= pending_idx;
    end
  end

  assign active_kbps = idx_kbps(8'(active_idx));
endmodule

// File: rtl/bitrate_svc_checker.sv
module bitrate_svc_checker
  import bitrate_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_fire,
  input logic             act_fire,
  input logic [7:0]       cfg_idx,
  input logic             switch_now,
  input logic             busy,
  input logic             store_cfg,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [10:0]      tx_id,
  input logic [3:0]       tx_len,
  input logic [63:0]      tx_data,
  input logic [IDX_W-1:0] pending_idx,
  input logic [IDX_W-1:0] active_idx,
  input logic [IDX_W-1:0] persist_idx
);
  p_resp_hdr_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_id == RSP_ID) && (tx_len == FRM_LEN) && (tx_data[7:0] == CMD_CFG));

  p_rsvd_reject_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_fire && cfg_idx == IDX_RSV) |=> tx_valid && (tx_data[15:8] == ST_BAD) && $stable(pending_idx));

  p_range_reject_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_fire && cfg_idx > IDX_TOP) |=> tx_valid && (tx_data[15:8] == ST_BAD) && $stable(pending_idx));

  p_cfg_no_side_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_fire && !store_cfg) |=> $stable(active_idx) && $stable(persist_idx));

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data));

  p_tx_block_r6: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> !cfg_fire && !act_fire);

  p_act_only_switch_r7: assert property (@(posedge clk) disable iff (rst)
    !switch_now |=> $stable(active_idx));

  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !cfg_fire && !act_fire);

  p_persist_store_r9: assert property (@(posedge clk) disable iff (rst)
    !store_cfg |=> $stable(persist_idx));
endmodule

bind bitrate_svc_handler bitrate_svc_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_fire(cfg_fire), .act_fire(act_fire),
  .cfg_idx(cfg_idx), .switch_now(switch_now), .busy(busy),
  .store_cfg(store_cfg), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_id(tx_id), .tx_len(tx_len), .tx_data(tx_data),
  .pending_idx(pending_idx), .active_idx(active_idx), .persist_idx(persist_idx)
);

// File: tb/sim_bitrate_svc_handler.sv
module sim_bitrate_svc_handler;
  localparam int INIT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0, por_n = 1'b0, ms_tick = 1'b0;
  logic rx_valid = 1'b0, store_cfg = 1'b0, tx_ready = 1'b1;
  logic [10:0] rx_id = '0;
  logic [3:0]  rx_len = '0;
  logic [63:0] rx_data = '0;
  logic        tx_valid, busy;
  logic [10:0] tx_id;
  logic [3:0]  tx_len;
  logic [63:0] tx_data;
  logic [3:0]  pending_idx, active_idx, persist_idx;
  logic [9:0]  active_kbps;

  int vectors = 0, fails = 0;
  int tick_period = 4, tick_cnt = 0;
  bit started = 0;

  always #5 clk = ~clk;

  bitrate_svc_handler u0 (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .ms_tick(ms_tick),
    .rx_valid(rx_valid), .rx_id(rx_id), .rx_len(rx_len), .rx_data(rx_data),
    .store_cfg(store_cfg), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_id(tx_id), .tx_len(tx_len), .tx_data(tx_data), .busy(busy),
    .pending_idx(pending_idx), .active_idx(active_idx),
    .persist_idx(persist_idx), .active_kbps(active_kbps)
  );

  // reference model
  int rate_tab [9] = '{1000, 800, 500, 250, 125, 0, 50, 20, 10};
  int m_pend = 0, m_act = 0, m_pers = 0, m_phase = 0, m_left = 0, m_dly = 0;
  bit m_txv = 0;
  logic [63:0] m_txd = '0;

  always @(posedge clk) begin
    int o_pend, o_pers, idx;
    bit take;
    started = 1;
    o_pend = m_pend; o_pers = m_pers;
    if (!rst_n || !por_n) begin
      if (!por_n) m_pers = INIT;
      m_act = o_pers; m_pend = o_pers;
      m_txv = 0; m_txd = '0; m_phase = 0; m_left = 0; m_dly = 0;
    end else begin
      take = rx_valid && rx_id == 11'h7E5 && rx_len == 4'd8 && m_phase == 0 && !m_txv;
      if (m_phase == 0) begin
        if (take && rx_data[7:0] == 8'h15) begin
          m_dly = int'(rx_data[15:8]) + 256 * int'(rx_data[23:16]);
          m_left = m_dly; m_phase = 1;
        end
      end else if (m_left == 0) begin
        if (m_phase == 1) begin m_act = o_pend; m_left = m_dly; m_phase = 2; end
        else m_phase = 0;
      end else if (ms_tick) m_left = m_left - 1;
      if (store_cfg) m_pers = o_pend;
      if (take && rx_data[7:0] == 8'h13) begin
        idx = int'(rx_data[23:16]);
        m_txv = 1;
        if (idx <= 8 && idx != 5) begin
          m_pend = idx; m_txd = 64'h0013;
        end else m_txd = 64'h0113;
      end else if (m_txv && tx_ready) m_txv = 0;
    end
  end

  task automatic cmp(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      cmp("R8 busy", int'(busy), int'(m_phase != 0));
      cmp("R7 active", int'(active_idx), m_act);
      cmp("R2 pending", int'(pending_idx), m_pend);
      cmp("R9 persist", int'(persist_idx), m_pers);
      cmp("R6 tx_valid", int'(tx_valid), int'(m_txv));
      cmp("R11 kbps", int'(active_kbps), rate_tab[m_act]);
      if (m_txv) begin
        cmp("R2 tx_lo", int'(tx_data[31:0]), int'(m_txd[31:0]));
        cmp("R2 tx_hi", int'(tx_data[63:32]), 0);
        cmp("R2 tx_id", int'(tx_id), 'h7E4);
        cmp("R2 tx_len", int'(tx_len), 8);
      end
    end
  end

  always @(negedge clk) begin
    tick_cnt = (tick_cnt + 1 >= tick_period) ? 0 : tick_cnt + 1;
    ms_tick = (tick_cnt == 0);
  end

  // frame: one cycle valid, then one idle cycle; returns at negedge after acceptance edge
  task automatic send(logic [10:0] id, logic [3:0] len, logic [7:0] b0, logic [7:0] b1, logic [7:0] b2);
    @(negedge clk);
    rx_valid = 1'b1; rx_id = id; rx_len = len; rx_data = {40'h0, b2, b1, b0};
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_free();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    por_n = 1'b1; rst_n = 1'b1;
    idle(1);
    cmp("R10 active after por", int'(active_idx), INIT);
    cmp("R10 pending after por", int'(pending_idx), INIT);
    cmp("R10 tx idle", int'(tx_valid), 0);

    send(11'h7E5, 4'd8, 8'h13, 8'h00, 8'd2);
    cmp("R2 status ok", int'(tx_data[15:8]), 0);
    cmp("R2 pending=2", int'(pending_idx), 2);
    idle(1);

    send(11'h7E5, 4'd8, 8'h13, 8'h00, 8'd5);
    cmp("R3 status bad", int'(tx_data[15:8]), 1);
    cmp("R3 pending kept", int'(pending_idx), 2);
    idle(1);
    send(11'h7E5, 4'd8, 8'h13, 8'h00, 8'd9);
    cmp("R4 status bad", int'(tx_data[15:8]), 1);
    cmp("R4 pending kept", int'(pending_idx), 2);
    idle(1);
    send(11'h7E5, 4'd8, 8'h13, 8'h00, 8'hFF);
    cmp("R4 pending kept ff", int'(pending_idx), 2);
    idle(1);

    send(11'h7E4, 4'd8, 8'h13, 8'h00, 8'd1);
    cmp("R1 wrong id no tx", int'(tx_valid), 0);
    send(11'h7E5, 4'd7, 8'h13, 8'h00, 8'd1);
    cmp("R1 wrong len no tx", int'(tx_valid), 0);
    send(11'h7E5, 4'd8, 8'h20, 8'h00, 8'd1);
    cmp("R1 bad cmd no tx", int'(tx_valid), 0);
    cmp("R1 pending kept", int'(pending_idx), 2);
    send(11'h7E5, 4'd7, 8'h15, 8'h00, 8'd0);
    cmp("R1 short activate no busy", int'(busy), 0);

    send(11'h7E5, 4'd8, 8'h13, 8'h00, 8'd7);
    cmp("R5 active kept", int'(active_idx), INIT);
    cmp("R5 persist kept", int'(persist_idx), INIT);
    idle(1);

    tx_ready = 1'b0;
    send(11'h7E5, 4'd8, 8'h13, 8'h00, 8'd3);
    send(11'h7E5, 4'd8, 8'h13, 8'h00, 8'd1);
    cmp("R6 held valid", int'(tx_valid), 1);
    cmp("R6 second ignored", int'(pending_idx), 3);
    tx_ready = 1'b1;
    idle(2);
    cmp("R6 drained", int'(tx_valid), 0);

    @(negedge clk); store_cfg = 1'b1;
    @(negedge clk); store_cfg = 1'b0;
    cmp("R9 stored", int'(persist_idx), 3);

    send(11'h7E5, 4'd8, 8'h15, 8'd3, 8'd0);
    cmp("R7 no response", int'(tx_valid), 0);
    cmp("R7 not yet active", int'(active_idx), INIT);
    cmp("R8 busy set", int'(busy), 1);
    send(11'h7E5, 4'd8, 8'h13, 8'h00, 8'd0);
    cmp("R8 ignored while busy", int'(pending_idx), 3);
    wait_free();
    cmp("R7 switched", int'(active_idx), 3);
    cmp("R11 rate 250", int'(active_kbps), 250);

    send(11'h7E5, 4'd8, 8'h13, 8'h00, 8'd8);
    idle(1);
    send(11'h7E5, 4'd8, 8'h15, 8'd0, 8'd0);
    idle(2);
    cmp("R7 zero delay", int'(active_idx), 8);
    cmp("R11 rate 10", int'(active_kbps), 10);
    wait_free();

    tick_period = 1;
    send(11'h7E5, 4'd8, 8'h13, 8'h00, 8'd6);
    idle(1);
    send(11'h7E5, 4'd8, 8'h15, 8'h02, 8'h01);
    idle(300);
    cmp("R7 little-endian delay", int'(active_idx), 6);
    cmp("R8 still busy", int'(busy), 1);
    wait_free();
    cmp("R8 busy ends", int'(busy), 0);

    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1;
    idle(1);
    cmp("R10 active from persist", int'(active_idx), 3);
    cmp("R10 pending from persist", int'(pending_idx), 3);
    @(negedge clk); por_n = 1'b0;
    idle(2); por_n = 1'b1;
    idle(1);
    cmp("R10 persist init", int'(persist_idx), INIT);
    cmp("R10 active init", int'(active_idx), INIT);
    idle(3);
    finish_run();
  end
endmodule